// File: doc/BRIEF.md
# Temperature Alarm Status Logic

This block watches a stream of signed temperature samples and keeps two status bits: one for over-temperature and one for under-temperature. Each direction has a trip threshold and a hysteresis (release) threshold. A sample is only considered in the cycle where its valid strobe is high. A fault must persist over a programmable number of consecutive samples before a status bit sets. The alarm pin is driven open-drain style whenever either status bit is set.

Each direction is controlled by one small state machine. It has four named states:

- `CH_ARM_TRIP`: status 0, waiting for qualified trip samples.
- `CH_HELD_TRIP`: status 1, entered on a trip.
- `CH_ARM_REL`: status 0, waiting for qualified release-side samples.
- `CH_HELD_REL`: status 1, entered on a release-side crossing.

The transitions are:

- **qualify-trip**: `CH_ARM_TRIP` → `CH_HELD_TRIP`.
- **cmp-release**: `CH_HELD_TRIP` → `CH_ARM_TRIP`, in comparator mode, on a sample past the hysteresis value.
- **read-ack-trip**: `CH_HELD_TRIP` → `CH_ARM_REL`, in interrupt mode, on a status read.
- **qualify-release**: `CH_ARM_REL` → `CH_HELD_REL`, in interrupt mode.
- **read-ack-release**: `CH_HELD_REL` → `CH_ARM_TRIP`, on a status read.
- **mode-fallback**: any release-phase state → `CH_ARM_TRIP` when comparator mode is selected.
- **shutdown**: any state → `CH_ARM_TRIP`.

A consecutive-sample counter, one per direction, qualifies every arming transition. A register file elsewhere supplies the four thresholds and the configuration word. Its reset values should be the `TAS_DEF_*` constants in the package:

| Threshold | Default |
|---|---|
| High trip | +100 °C |
| High hysteresis | +90 °C |
| Low trip | −40 °C |
| Low hysteresis | −30 °C |

Top module: `temp_alarm_status`

## Requirements
- R1: Samples and thresholds are 16-bit two's complement values (1 LSB = 0.0625 °C). All comparisons are strict. Comparisons happen only in a cycle with `smp_valid` high. A status bit changes on the clock edge of that sample and is visible after it. Changing thresholds without a valid sample changes nothing.
- R2: Comparator mode (`cfg_reg[9]`=0), over-temperature. `ot_flag` sets after the qualified number of samples with temperature > `hi_trip`. It clears on a sample with temperature < `hi_hyst`. Between the two thresholds, or exactly on either one, it holds.
- R3: Comparator mode, under-temperature. `ut_flag` sets after qualified samples with temperature < `lo_trip`. It clears on a sample with temperature > `lo_hyst`.
- R4: In comparator mode, `stat_rd` has no effect on either status bit.
- R5: Interrupt mode (`cfg_reg[9]`=1). A qualified trip sets the status bit. The bit stays set whatever later samples show, until a `stat_rd` pulse clears it.
- R6: Interrupt mode. After a read clears a bit that was set by a trip, the bit sets again only on qualified samples on the release side: below `hi_hyst` for over-temperature, above `lo_hyst` for under-temperature. After the next read it re-arms on the trip threshold, and the cycle repeats.
- R7: The fault-queue field `cfg_reg[11:10]`=k requires 2^k consecutive qualifying samples (1, 2, 4 or 8). Any valid sample that does not qualify restarts the count.
- R8: `shutdown_req` clears both status bits and both counters in the next cycle. It overrides any sample or read in the same cycle.
- R9: When `stat_rd` clears a bit in the same cycle as a valid sample, that sample does not count toward the newly armed condition.
- R10: Alarm output. `alarm_oe` is 1 exactly when either status bit is 1. `alarm_lvl` equals `cfg_reg[8]` (1 = active-high) while driving, and its inverse while released.
- R11: If comparator mode is selected while a channel is in a release-phase state, the channel returns to trip arming with status 0 on the next clock.
- R12: In comparator mode, clearing on the hysteresis side takes a single sample, whatever the fault-queue setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New sample strobe |
| smp_temp | input | 16 | Signed sample, 0.0625 °C per LSB |
| hi_trip | input | 16 | Over-temperature threshold |
| hi_hyst | input | 16 | Over-temperature hysteresis value |
| lo_trip | input | 16 | Under-temperature threshold |
| lo_hyst | input | 16 | Under-temperature hysteresis value |
| cfg_reg | input | 16 | Config word: [11:10] fault queue, [9] interrupt mode, [8] active-high polarity; other bits unused |
| stat_rd | input | 1 | Status-register read strobe |
| shutdown_req | input | 1 | Shutdown: clears status |
| ot_flag | output | 1 | Over-temperature status |
| ut_flag | output | 1 | Under-temperature status |
| alarm_oe | output | 1 | Alarm pin actively driven |
| alarm_lvl | output | 1 | Alarm pin level |

## Verification
The status-read acknowledge and the sample qualifier can act in the same cycle. A read that releases a held bit may coincide with a valid sample that already meets the newly armed condition. The bench provokes this by issuing a read and a faulting sample together, under a fault queue of two. The behavioural model then expects the bit to stay clear until two further samples arrive. Shutdown is likewise raised together with a read and a faulting sample, and the model expects shutdown to win.

// File: rtl/tas_pkg.sv
package tas_pkg;
    localparam int TAS_W = 16;
    localparam int TAS_QW = 2;

    localparam int CFG_QSEL_LSB = 10;
    localparam int CFG_MODE_BIT = 9;
    localparam int CFG_POL_BIT = 8;

    localparam logic signed [TAS_W-1:0] TAS_DEF_HI_TRIP = 16'sd1600;
    localparam logic signed [TAS_W-1:0] TAS_DEF_HI_HYST = 16'sd1440;
    localparam logic signed [TAS_W-1:0] TAS_DEF_LO_TRIP = -16'sd640;
    localparam logic signed [TAS_W-1:0] TAS_DEF_LO_HYST = -16'sd480;

    typedef enum logic [1:0] {
        CH_ARM_TRIP  = 2'd0,
        CH_HELD_TRIP = 2'd1,
        CH_ARM_REL   = 2'd2,
        CH_HELD_REL  = 2'd3
    } ch_state_e;
endpackage

// File: rtl/tas_compare.sv
module tas_compare #(
    parameter int W = 16
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] hi_trip,
    input  logic [W-1:0] hi_hyst,
    input  logic [W-1:0] lo_trip,
    input  logic [W-1:0] lo_hyst,
    output logic [1:0]   trip_cond,
    output logic [1:0]   rel_cond
);
    // index 0 = over-temperature, index 1 = under-temperature
    always_comb begin
        trip_cond[0] = $signed(sample) > $signed(hi_trip);
        rel_cond[0]  = $signed(sample) < $signed(hi_hyst);
        trip_cond[1] = $signed(sample) < $signed(lo_trip);
        rel_cond[1]  = $signed(sample) > $signed(lo_hyst);
    end
endmodule

// File: rtl/tas_qualifier.sv
module tas_qualifier #(
    parameter int QW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          valid,
    input  logic          cond,
    input  logic [QW-1:0] depth_sel,
    output logic          hit
);
    localparam int MAXN = 1 << ((1 << QW) - 1);
    localparam int CW = $clog2(MAXN) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] need;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        need    = CW'(1) << depth_sel;
        cnt_inc = cnt + CW'(1);
        hit     = valid && cond && (cnt_inc >= need);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || hit) begin
            cnt <= '0;
        end else if (valid) begin
            cnt <= cond ? cnt_inc : '0;
        end
    end

    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAXN));
    a_r7_nonfault_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !cond) |=> (cnt == '0));
endmodule

// File: rtl/tas_channel.sv
module tas_channel
    import tas_pkg::*;
#(
    parameter int QW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_valid,
    input  logic          trip_cond,
    input  logic          rel_cond,
    input  logic          irq_mode,
    input  logic          rd_ack,
    input  logic          shutdown,
    input  logic [QW-1:0] depth_sel,
    output logic          flag
);
    ch_state_e state, state_nx;
    logic q_cond, q_clear, q_hit;

    always_comb begin
        q_cond  = (state == CH_ARM_REL) ? rel_cond : trip_cond;
        q_clear = shutdown
               || (state == CH_HELD_TRIP) || (state == CH_HELD_REL)
               || ((state == CH_ARM_REL) && !irq_mode);
    end

    tas_qualifier #(.QW(QW)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (q_clear),
        .valid    (sample_valid),
        .cond     (q_cond),
        .depth_sel(depth_sel),
        .hit      (q_hit)
    );

    always_comb begin
        state_nx = state;
        if (shutdown) begin
            state_nx = CH_ARM_TRIP;
        end else begin
            unique case (state)
                CH_ARM_TRIP: begin
                    if (q_hit) state_nx = CH_HELD_TRIP;
                end
                CH_HELD_TRIP: begin
                    if (!irq_mode) begin
                        if (sample_valid && rel_cond) state_nx = CH_ARM_TRIP;
                    end else if (rd_ack) begin
                        state_nx = CH_ARM_REL;
                    end
                end
                CH_ARM_REL: begin
                    if (!irq_mode) state_nx = CH_ARM_TRIP;
                    else if (q_hit) state_nx = CH_HELD_REL;
                end
                CH_HELD_REL: begin
                    if (!irq_mode || rd_ack) state_nx = CH_ARM_TRIP;
                end
                default: state_nx = CH_ARM_TRIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_ARM_TRIP;
        else        state <= state_nx;
    end

    always_comb begin
        flag = (state == CH_HELD_TRIP) || (state == CH_HELD_REL);
    end

    a_r8_shutdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> !flag);
    a_r1_set_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(sample_valid));
    a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && irq_mode && !rd_ack && !shutdown) |=> flag);
    a_r4_cmp_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_HELD_TRIP && !irq_mode && !sample_valid && !shutdown) |=> flag);
    a_r11_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_ARM_REL && !irq_mode) |=> !flag);
endmodule

// File: rtl/tas_alarm_drive.sv
module tas_alarm_drive #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] flags,
    input  logic           active_high,
    output logic           oe,
    output logic           lvl
);
    always_comb begin
        oe  = |flags;
        lvl = oe ? active_high : !active_high;
    end
endmodule

// File: rtl/temp_alarm_status.sv
module temp_alarm_status
    import tas_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_valid,
    input  logic [15:0] smp_temp,
    input  logic [15:0] hi_trip,
    input  logic [15:0] hi_hyst,
    input  logic [15:0] lo_trip,
    input  logic [15:0] lo_hyst,
    input  logic [15:0] cfg_reg,
    input  logic        stat_rd,
    input  logic        shutdown_req,
    output logic        ot_flag,
    output logic        ut_flag,
    output logic        alarm_oe,
    output logic        alarm_lvl
);
    localparam int NCH = 2;

    logic [NCH-1:0]    trip_c, rel_c, flags;
    logic [TAS_QW-1:0] depth_sel;
    logic              irq_mode, pol_high;

    always_comb begin
        depth_sel = cfg_reg[CFG_QSEL_LSB +: TAS_QW];
        irq_mode  = cfg_reg[CFG_MODE_BIT];
        pol_high  = cfg_reg[CFG_POL_BIT];
    end

    tas_compare #(.W(TAS_W)) u_cmp (
        .sample   (smp_temp),
        .hi_trip  (hi_trip),
        .hi_hyst  (hi_hyst),
        .lo_trip  (lo_trip),
        .lo_hyst  (lo_hyst),
        .trip_cond(trip_c),
        .rel_cond (rel_c)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        tas_channel #(.QW(TAS_QW)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .sample_valid(smp_valid),
            .trip_cond   (trip_c[ch]),
            .rel_cond    (rel_c[ch]),
            .irq_mode    (irq_mode),
            .rd_ack      (stat_rd),
            .shutdown    (shutdown_req),
            .depth_sel   (depth_sel),
            .flag        (flags[ch])
        );
    end

    tas_alarm_drive #(.NCH(NCH)) u_drv (
        .flags      (flags),
        .active_high(pol_high),
        .oe         (alarm_oe),
        .lvl        (alarm_lvl)
    );

    always_comb begin
        ot_flag = flags[0];
        ut_flag = flags[1];
    end

    a_r10_alarm_follows_status: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag || ut_flag) |-> (alarm_oe && alarm_lvl == cfg_reg[CFG_POL_BIT]));
    a_r12_cmp_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag && !irq_mode && smp_valid && rel_c[0] && !shutdown_req) |=> !ot_flag);
endmodule

// File: tb/tb_temp_alarm_status.sv
module tb_temp_alarm_status;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        smp_valid = 0;
    logic [15:0] smp_temp = '0;
    logic [15:0] hi_trip = 16'd1600, hi_hyst = 16'd1440;
    logic [15:0] lo_trip = 16'hFD80, lo_hyst = 16'hFE20; // -640, -480
    logic [15:0] cfg_reg = '0;
    logic        stat_rd = 0, shutdown_req = 0;
    logic        ot_flag, ut_flag, alarm_oe, alarm_lvl;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;
    int    ph[2];
    int    cnt[2];

    temp_alarm_status dut (.*);

    always #5 clk = ~clk;

    // Behavioural reference: phase 0 idle/trip-armed, 1 held by trip,
    // 2 release-armed, 3 held by release; odd phase means status set.
    always @(posedge clk) begin
        int t, need;
        bit irq;
        t    = $signed(smp_temp);
        need = 1 << cfg_reg[11:10];
        irq  = cfg_reg[9];
        for (int c = 0; c < 2; c++) begin
            bit tr, rl, cond;
            tr = (c == 0) ? (t > $signed(hi_trip)) : (t < $signed(lo_trip));
            rl = (c == 0) ? (t < $signed(hi_hyst)) : (t > $signed(lo_hyst));
            if (!rst_n || shutdown_req) begin
                ph[c] = 0; cnt[c] = 0;
            end else if (ph[c] == 1) begin
                cnt[c] = 0;
                if (!irq) begin if (smp_valid && rl) ph[c] = 0; end
                else if (stat_rd) ph[c] = 2;
            end else if (ph[c] == 3) begin
                cnt[c] = 0;
                if (!irq || stat_rd) ph[c] = 0;
            end else if (ph[c] == 2 && !irq) begin
                ph[c] = 0; cnt[c] = 0;
            end else if (smp_valid) begin
                cond = (ph[c] == 0) ? tr : rl;
                if (!cond) cnt[c] = 0;
                else if (cnt[c] + 1 >= need) begin cnt[c] = 0; ph[c] = ph[c] + 1; end
                else cnt[c] = cnt[c] + 1;
            end
        end
        #2;
        if (!done) compare();
    end

    task automatic compare();
        bit eo, eu, eoe, elv;
        eo  = ph[0][0];
        eu  = ph[1][0];
        eoe = eo | eu;
        elv = eoe ? cfg_reg[8] : !cfg_reg[8];
        n_vec++;
        if (ot_flag !== eo || ut_flag !== eu || alarm_oe !== eoe || alarm_lvl !== elv) begin
            n_bad++;
            $display("FAIL %s t=%0t: ot/ut/oe/lvl actual %b%b%b%b expected %b%b%b%b",
                     cur_req, $time, ot_flag, ut_flag, alarm_oe, alarm_lvl, eo, eu, eoe, elv);
        end
    endtask

    task automatic cyc(input bit v, input int deg16, input bit rd, input bit sd);
        @(negedge clk);
        smp_valid = v; smp_temp = 16'(deg16); stat_rd = rd; shutdown_req = sd;
    endtask

    task automatic smp(input int deg);
        cyc(1, deg * 16, 0, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    task automatic setcfg(input int q, input bit irq, input bit pol);
        @(negedge clk);
        smp_valid = 0; stat_rd = 0; shutdown_req = 0;
        cfg_reg = {4'b0, 2'(q), irq, pol, 8'h00};
    endtask

    task automatic rd();
        cyc(0, 0, 1, 0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        cur_req = "R10"; // reset state: no status, alarm released
        idle(3);
        @(negedge clk) rst_n = 1;
        idle(2);

        cur_req = "R2";
        smp(25); smp(101); smp(100); smp(95); smp(90); idle(1); smp(89); idle(2);

        cur_req = "R1"; // exactly on threshold does not trip; threshold change w/o sample
        smp(100); idle(1);
        @(negedge clk) hi_trip = 16'd0;
        idle(3);
        smp(5); smp(-1); smp(-1); idle(1);
        @(negedge clk) hi_trip = 16'd1600;
        smp(25);

        cur_req = "R3";
        smp(-41); smp(-40); smp(-30); smp(-29); idle(2);

        cur_req = "R4";
        smp(120); rd(); rd(); idle(1); cyc(1, 120 * 16, 1, 0); smp(20);
        smp(-50); rd(); smp(0);

        cur_req = "R7";
        setcfg(2, 0, 0);
        smp(110); smp(110); smp(110); smp(50); smp(110); smp(110); smp(110); idle(1);
        smp(110); idle(2);
        cur_req = "R12";
        smp(80); idle(1);
        cur_req = "R7";
        setcfg(3, 0, 0);
        for (int i = 0; i < 7; i++) smp(-60);
        idle(1); smp(-60); idle(2); smp(0);
        setcfg(1, 0, 0);
        smp(-60); smp(-20); smp(-60); smp(-60); smp(0);

        cur_req = "R5";
        setcfg(0, 1, 0);
        smp(101); smp(0); smp(50); idle(2); rd(); idle(1);
        cur_req = "R6";
        smp(95); smp(91); smp(80); idle(1); smp(200); rd(); smp(80); smp(101); idle(1);
        rd(); smp(-41); smp(-35); rd(); smp(-35); smp(-29); rd(); smp(-29); smp(-41); rd();

        cur_req = "R9";
        setcfg(1, 1, 0);
        smp(101); smp(101); idle(1);
        cyc(1, 0, 1, 0); smp(0); idle(1); smp(0); idle(1); rd();

        cur_req = "R8";
        smp(101); smp(101); smp(-50); smp(-50); idle(1);
        cyc(1, 120 * 16, 1, 1); idle(1); smp(101); cyc(1, 101 * 16, 0, 1); smp(101); idle(1);
        smp(101); smp(101); cyc(0, 0, 0, 1); idle(1);

        cur_req = "R10";
        setcfg(0, 0, 1);
        smp(101); idle(1); smp(20); smp(-45); smp(-10); idle(1);

        cur_req = "R11";
        setcfg(0, 1, 0);
        smp(101); rd(); idle(1);
        setcfg(0, 0, 0); idle(2);
        setcfg(0, 1, 0); smp(101); rd(); smp(0); idle(1);
        setcfg(0, 0, 0); idle(2);
        smp(101); smp(30); idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule